// File: doc/BRIEF.md
# Interrupt Controller Register Bank

This block is the memory-mapped front end of a 64-source interrupt controller. Software reaches it over a simple single-cycle, word-addressed bus. It holds the per-source pending, enable and type (normal or fast) state, a 4-bit priority for each source, a 5-bit normal-interrupt mask threshold and a small control register. It instantiates the arbiter that picks the winning normal and fast sources and drives the two interrupt request lines.

Level inputs from the 64 sources set and clear pending bits on their transitions. Software can also overwrite either half of the pending vector directly. Two vector/status words acknowledge on read: each returns the winning source and clears that source's pending bit in the same access. Enables can be changed as whole 32-bit halves or one source at a time by writing the source number. The hardware vector table region takes no writes. One fixed word in that region reads back a constant.

Reads are combinational from the current state. Every state change, including the clear caused by a vector read, takes effect at the clock edge that ends the access.

Top module: `intc_regbank`

## Requirements
- R1: After reset the mask word reads 0x1F. The control, enable, type, priority and pending words all read 0.
- R2: A pending bit is set on the clock edge after its input rises and cleared on the edge after it falls, and it holds otherwise. In a cycle where a force write or a vector-read clear touches that bit, the bus action wins over the input transition.
- R3: A write to word 2 sets the enable bit numbered by wdata[5:0]. A write to word 3 clears that bit. Reads of words 2 and 3 return 0.
- R4: Words 4/5 hold the enable vector bits 63:32 and 31:0. Words 6/7 hold the type vector the same way, where 1 means fast. All four read back what was written.
- R5: Word 8+k holds the priorities of group 7-k, which is sources 8*(7-k) to 8*(7-k)+7. Source n's priority is at bits 4*(n%8)+3 : 4*(n%8) of its group word. Reads use the same mapping.
- R6: Word 16 picks, among sources that are pending, enabled and normal, the one with the highest priority; on a tie the highest index wins. A read returns (index<<16)|priority and clears that pending bit. With no candidate the read returns 0xFFFFFFFF.
- R7: A read of word 17 returns the lowest index that is pending, enabled and fast, and clears its pending bit. With no candidate it returns 0xFFFFFFFF.
- R8: A write to word 20 replaces pending bits 63:32 and a write to word 21 replaces bits 31:0. Both words read 0. Words 18/19 read the raw pending bits 63:32 and 31:0.
- R9: Words 22/23 read pending&enable&~type and words 24/25 read pending&enable&type, high half first.
- R10: Writes to words 16 to 19 and 22 to 25 change no state.
- R11: Word 1 keeps wdata[4:0]. Word 0 keeps wdata[5:0]; its bus-flag bit 6 is write-1-to-clear, is never set by hardware, and reads 0.
- R12: irq_fast is high when any source is pending, enabled and fast. irq_norm is high when some source is pending, enabled and normal and either the mask is 0x1F or one such source has a priority strictly above the mask.
- R13: Writes to words 0x40 to 0xBF are dropped. A read of word 0x40 returns 4. All other unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 64 | Level request from each source |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
The assertions check on every cycle that a successful vector read clears the returned source's pending bit on the next edge. They also check that a fast vector read returns a valid index exactly when irq_fast is high, that with the mask at 0x1F a normal vector read and irq_norm agree, that a low force write lands exactly, and that the mask comes out of reset at 0x1F. Only the bench scenarios can show the tie rule between equal priorities, the inverted priority-word mapping, the threshold comparison against the mask, the race between an input edge and a force write, and the dropped writes to read-only and table words.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
    localparam int NUM_SRC = 64;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 10;
    localparam int PRIO_W  = 4;
    localparam int MASK_W  = 5;
    localparam int CTL_W   = 6;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int PER_GRP = DATA_W / PRIO_W;
    localparam int GRP_N   = NUM_SRC / PER_GRP;
    localparam int VTAB_LO = 'h40;
    localparam int VTAB_HI = 'hBF;
    localparam logic [MASK_W-1:0] MASK_OFF = '1;

    typedef enum logic [4:0] {
        K_CTL, K_MASK, K_ENNUM, K_DISNUM, K_ENH, K_ENL, K_TYH, K_TYL,
        K_PRIO, K_NVEC, K_FVEC, K_SRCH, K_SRCL, K_FRCH, K_FRCL,
        K_NPH, K_NPL, K_FPH, K_FPL, K_VEC0, K_VTAB, K_NONE
    } reg_kind_e;

    function automatic reg_kind_e decode(input logic [ADDR_W-1:0] a);
        reg_kind_e k;
        k = K_NONE;
        if (a >= ADDR_W'(8) && a <= ADDR_W'(15)) k = K_PRIO;
        else if (a == ADDR_W'(VTAB_LO))        k = K_VEC0;
        else if (a > ADDR_W'(VTAB_LO) && a <= ADDR_W'(VTAB_HI)) k = K_VTAB;
        else begin
            unique case (a)
                ADDR_W'(0):  k = K_CTL;
                ADDR_W'(1):  k = K_MASK;
                ADDR_W'(2):  k = K_ENNUM;
                ADDR_W'(3):  k = K_DISNUM;
                ADDR_W'(4):  k = K_ENH;
                ADDR_W'(5):  k = K_ENL;
                ADDR_W'(6):  k = K_TYH;
                ADDR_W'(7):  k = K_TYL;
                ADDR_W'(16): k = K_NVEC;
                ADDR_W'(17): k = K_FVEC;
                ADDR_W'(18): k = K_SRCH;
                ADDR_W'(19): k = K_SRCL;
                ADDR_W'(20): k = K_FRCH;
                ADDR_W'(21): k = K_FRCL;
                ADDR_W'(22): k = K_NPH;
                ADDR_W'(23): k = K_NPL;
                ADDR_W'(24): k = K_FPH;
                ADDR_W'(25): k = K_FPL;
                default:     k = K_NONE;
            endcase
        end
        return k;
    endfunction
endpackage

// File: rtl/intc_pend_bit.sv
`timescale 1ns/1ps
module intc_pend_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic frc_en,
    input  logic frc_val,
    input  logic clr,
    output logic pend
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            prev_q <= src;
            if (frc_en)             pend <= frc_val;
            else if (clr)           pend <= 1'b0;
            else if (src && !prev_q) pend <= 1'b1;
            else if (!src && prev_q) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/intc_arbiter.sv
`timescale 1ns/1ps
module intc_arbiter
    import intc_pkg::*;
(
    input  logic [NUM_SRC-1:0]        act_norm,
    input  logic [NUM_SRC-1:0]        act_fast,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [MASK_W-1:0]         mask,
    output logic                      n_vld,
    output logic [IDX_W-1:0]          n_idx,
    output logic [PRIO_W-1:0]         n_prio,
    output logic                      f_vld,
    output logic [IDX_W-1:0]          f_idx,
    output logic                      irq_norm,
    output logic                      irq_fast
);
    logic any_above;

    always_comb begin
        n_vld     = 1'b0;
        n_idx     = '0;
        n_prio    = '0;
        any_above = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (act_norm[i]) begin
                if (!n_vld || prio_flat[i*PRIO_W +: PRIO_W] >= n_prio) begin
                    n_vld  = 1'b1;
                    n_idx  = IDX_W'(i);
                    n_prio = prio_flat[i*PRIO_W +: PRIO_W];
                end
                if ({1'b0, prio_flat[i*PRIO_W +: PRIO_W]} > mask) any_above = 1'b1;
            end
        end
    end

    always_comb begin
        f_vld = 1'b0;
        f_idx = '0;
        for (int i = NUM_SRC-1; i >= 0; i--) begin
            if (act_fast[i]) begin
                f_vld = 1'b1;
                f_idx = IDX_W'(i);
            end
        end
    end

    assign irq_norm = n_vld && (mask == MASK_OFF || any_above);
    assign irq_fast = f_vld;
endmodule

// File: rtl/intc_regbank.sv
`timescale 1ns/1ps
module intc_regbank
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [63:0]        src_in,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [9:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_norm,
    output logic               irq_fast
);
    localparam int HALF = NUM_SRC / 2;

    reg_kind_e                 kind;
    logic                      wr_stb, rd_stb;
    logic [NUM_SRC-1:0]        en_q, typ_q, pend_q;
    logic [DATA_W-1:0]         prio_q [GRP_N];
    logic [MASK_W-1:0]         mask_q;
    logic [CTL_W-1:0]          ctl_q;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [NUM_SRC-1:0]        act_norm, act_fast, clr_vec, frc_en;
    logic                      n_vld, f_vld;
    logic [IDX_W-1:0]          n_idx, f_idx;
    logic [PRIO_W-1:0]         n_prio;

    assign kind     = decode(bus_addr);
    assign wr_stb   = bus_sel && bus_wr;
    assign rd_stb   = bus_sel && !bus_wr;
    assign act_norm = pend_q & en_q & ~typ_q;
    assign act_fast = pend_q & en_q & typ_q;

    always_comb begin
        clr_vec = '0;
        if (rd_stb && kind == K_NVEC && n_vld) clr_vec[n_idx] = 1'b1;
        if (rd_stb && kind == K_FVEC && f_vld) clr_vec[f_idx] = 1'b1;
    end

    assign frc_en = {{HALF{wr_stb && kind == K_FRCH}}, {HALF{wr_stb && kind == K_FRCL}}};

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        assign prio_flat[n*PRIO_W +: PRIO_W] = prio_q[n / PER_GRP][(n % PER_GRP)*PRIO_W +: PRIO_W];
        intc_pend_bit u_pend (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (src_in[n]),
            .frc_en  (frc_en[n]),
            .frc_val (bus_wdata[n % HALF]),
            .clr     (clr_vec[n]),
            .pend    (pend_q[n])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            typ_q  <= '0;
            mask_q <= MASK_OFF;
            ctl_q  <= '0;
            for (int g = 0; g < GRP_N; g++) prio_q[g] <= '0;
        end else if (wr_stb) begin
            unique case (kind)
                K_CTL:    ctl_q <= bus_wdata[CTL_W-1:0];
                K_MASK:   mask_q <= bus_wdata[MASK_W-1:0];
                K_ENNUM:  en_q[bus_wdata[IDX_W-1:0]] <= 1'b1;
                K_DISNUM: en_q[bus_wdata[IDX_W-1:0]] <= 1'b0;
                K_ENH:    en_q[NUM_SRC-1:HALF] <= bus_wdata;
                K_ENL:    en_q[HALF-1:0] <= bus_wdata;
                K_TYH:    typ_q[NUM_SRC-1:HALF] <= bus_wdata;
                K_TYL:    typ_q[HALF-1:0] <= bus_wdata;
                K_PRIO:   prio_q[~bus_addr[2:0]] <= bus_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (kind)
            K_CTL:  bus_rdata = DATA_W'(ctl_q);
            K_MASK: bus_rdata = DATA_W'(mask_q);
            K_ENH:  bus_rdata = en_q[NUM_SRC-1:HALF];
            K_ENL:  bus_rdata = en_q[HALF-1:0];
            K_TYH:  bus_rdata = typ_q[NUM_SRC-1:HALF];
            K_TYL:  bus_rdata = typ_q[HALF-1:0];
            K_PRIO: bus_rdata = prio_q[~bus_addr[2:0]];
            K_NVEC: bus_rdata = n_vld ? ((DATA_W'(n_idx) << 16) | DATA_W'(n_prio)) : '1;
            K_FVEC: bus_rdata = f_vld ? DATA_W'(f_idx) : '1;
            K_SRCH: bus_rdata = pend_q[NUM_SRC-1:HALF];
            K_SRCL: bus_rdata = pend_q[HALF-1:0];
            K_NPH:  bus_rdata = act_norm[NUM_SRC-1:HALF];
            K_NPL:  bus_rdata = act_norm[HALF-1:0];
            K_FPH:  bus_rdata = act_fast[NUM_SRC-1:HALF];
            K_FPL:  bus_rdata = act_fast[HALF-1:0];
            K_VEC0: bus_rdata = 32'd4;
            default: bus_rdata = '0;
        endcase
    end

    intc_arbiter u_arb (
        .act_norm  (act_norm),
        .act_fast  (act_fast),
        .prio_flat (prio_flat),
        .mask      (mask_q),
        .n_vld     (n_vld),
        .n_idx     (n_idx),
        .n_prio    (n_prio),
        .f_vld     (f_vld),
        .f_idx     (f_idx),
        .irq_norm  (irq_norm),
        .irq_fast  (irq_fast)
    );
endmodule

// File: rtl/intc_regbank_chk.sv
`timescale 1ns/1ps
module intc_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [9:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        irq_norm,
    input logic        irq_fast,
    input logic [63:0] pend_q,
    input logic [4:0]  mask_q
);
    logic rd_n, rd_f, rd_num, wr_flo;
    assign rd_n   = bus_sel && !bus_wr && bus_addr == 10'd16;
    assign rd_f   = bus_sel && !bus_wr && bus_addr == 10'd17;
    assign rd_num = bus_sel && !bus_wr && (bus_addr == 10'd2 || bus_addr == 10'd3);
    assign wr_flo = bus_sel && bus_wr && bus_addr == 10'd21;

    AST_RESET_MASK: assert property (@(posedge clk) $rose(rst_n) |-> mask_q == 5'h1F); // R1
    AST_NUM_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_num |-> bus_rdata == 32'd0); // R3
    AST_NORM_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd_n && bus_rdata != 32'hFFFF_FFFF) |=> !pend_q[$past(bus_rdata[21:16])]); // R6
    AST_FAST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd_f && bus_rdata != 32'hFFFF_FFFF) |=> !pend_q[$past(bus_rdata[5:0])]); // R7
    AST_FORCE_LOW_EXACT: assert property (@(posedge clk) disable iff (!rst_n) wr_flo |=> pend_q[31:0] == $past(bus_wdata)); // R8
    AST_FAST_REQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n) rd_f |-> ((bus_rdata != 32'hFFFF_FFFF) == irq_fast)); // R12
    AST_NORM_REQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n) (rd_n && mask_q == 5'h1F) |-> ((bus_rdata != 32'hFFFF_FFFF) == irq_norm)); // R12
endmodule

bind intc_regbank intc_regbank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_norm  (irq_norm),
    .irq_fast  (irq_fast),
    .pend_q    (pend_q),
    .mask_q    (mask_q)
);

// File: tb/test_intc_regbank.sv
`timescale 1ns/1ps
module test_intc_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        sel = 1'b0, we = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_n, irq_f;
    int          n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    intc_regbank i_intc_regbank (
        .clk (clk), .rst_n (rst_n), .src_in (src), .bus_sel (sel), .bus_wr (we),
        .bus_addr (addr), .bus_wdata (wdata), .bus_rdata (rdata),
        .irq_norm (irq_n), .irq_fast (irq_f)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); sel = 1'b1; we = 1'b1; addr = 10'(a); wdata = d;
        @(negedge clk); sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk); sel = 1'b1; we = 1'b0; addr = 10'(a);
        #1 d = rdata;
        @(negedge clk); sel = 1'b0;
    endtask

    task automatic rchk(input string tag, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic set_src(input logic [63:0] v);
        @(negedge clk); src = v;
    endtask

    task automatic t_reset;
        rchk("R1 mask", 1, 32'h1F);
        rchk("R1 ctl", 0, 0);
        rchk("R1 enable low", 5, 0);
        rchk("R1 type high", 6, 0);
        rchk("R1 prio word", 15, 0);
        rchk("R1 pending low", 19, 0);
    endtask

    task automatic t_pending;
        set_src(64'h8);
        rchk("R2 rise sets", 19, 32'h8);
        wr(21, 0);
        rchk("R2 held input no reset", 19, 0);
        set_src(64'h0);
        rchk("R2 fall on cleared bit", 19, 0);
        set_src(64'h8);
        rchk("R2 rise again", 19, 32'h8);
        set_src(64'h0);
        rchk("R2 fall clears", 19, 0);
        @(negedge clk); src = 64'h80; sel = 1'b1; we = 1'b1; addr = 10'd21; wdata = 0;
        @(negedge clk); sel = 1'b0; we = 1'b0;
        rchk("R2 force beats rise", 19, 0);
        set_src(64'h0);
    endtask

    task automatic t_enable_num;
        wr(2, 32'h45);
        wr(2, 32'd40);
        rchk("R3 enable by number low", 5, 32'h20);
        rchk("R3 enable by number high", 4, 32'h100);
        rchk("R3 word 2 reads zero", 2, 0);
        wr(3, 32'd5);
        rchk("R3 disable by number", 5, 0);
        rchk("R3 word 3 reads zero", 3, 0);
    endtask

    task automatic t_halves;
        wr(5, 32'hFFFF_0000); wr(4, 32'h0000_00FF);
        rchk("R4 enable low", 5, 32'hFFFF_0000);
        rchk("R4 enable high", 4, 32'h0000_00FF);
        wr(7, 32'h0000_000F); wr(6, 32'hA000_0000);
        rchk("R4 type low", 7, 32'hF);
        rchk("R4 type high", 6, 32'hA000_0000);
        wr(6, 0); wr(7, 0);
    endtask

    task automatic t_norm_vec;
        wr(4, '1); wr(5, '1);
        wr(8, 32'h1234_5678); wr(15, 32'h9ABC_DEF0);
        rchk("R5 word 8 readback", 8, 32'h1234_5678);
        rchk("R5 word 15 readback", 15, 32'h9ABC_DEF0);
        wr(20, 32'h8000_0000); wr(21, 32'h2);
        rchk("R6 R5 higher prio wins", 16, 32'h0001_000F);
        rchk("R6 R5 next winner", 16, 32'h003F_0001);
        rchk("R6 empty", 16, 32'hFFFF_FFFF);
        wr(8, 0); wr(15, 32'h33);
        wr(21, 32'h3);
        rchk("R6 tie goes to higher index", 16, 32'h0001_0003);
        rchk("R6 ack cleared only winner", 19, 32'h1);
        wr(21, 0); wr(15, 0);
    endtask

    task automatic t_fast_vec;
        wr(7, 32'h30); wr(6, 32'h1);
        wr(21, 32'h34); wr(20, 32'h1);
        rchk("R9 fast low", 25, 32'h30);
        rchk("R9 fast high", 24, 32'h1);
        rchk("R9 normal low", 23, 32'h4);
        rchk("R9 normal high", 22, 0);
        wr(5, 32'hFFFF_FFEF);
        rchk("R9 disabled excluded", 25, 32'h20);
        wr(5, '1);
        rchk("R7 lowest fast", 17, 32'd4);
        rchk("R7 next fast", 17, 32'd5);
        rchk("R7 upper half", 17, 32'd32);
        rchk("R7 empty", 17, 32'hFFFF_FFFF);
        wr(6, 0); wr(7, 0); wr(21, 0);
    endtask

    task automatic t_force;
        wr(20, 32'h0F00_0001);
        rchk("R8 source high", 18, 32'h0F00_0001);
        rchk("R8 force high reads zero", 20, 0);
        rchk("R8 force low reads zero", 21, 0);
        wr(20, 0);
    endtask

    task automatic t_readonly;
        wr(21, 32'h1);
        wr(16, 0); wr(17, 0); wr(18, 0); wr(19, 0); wr(23, 0); wr(25, 0);
        rchk("R10 writes to read-only words ignored", 19, 32'h1);
        wr(21, 0);
    endtask

    task automatic t_mask_ctl;
        wr(1, 32'hFFFF_FFE3);
        rchk("R11 mask keeps five bits", 1, 32'h3);
        wr(0, 32'hFFFF_FFFF);
        rchk("R11 control keeps defined bits", 0, 32'h3F);
        wr(0, 0);
    endtask

    task automatic t_irq;
        wr(15, 32'h50); wr(1, 32'h1F); wr(21, 0);
        #1 check("R12 no pending", {30'b0, irq_n, irq_f}, 0);
        wr(21, 32'h1);
        #1 check("R12 mask off passes prio 0", {31'b0, irq_n}, 1);
        wr(1, 0);
        #1 check("R12 prio equal to mask blocked", {31'b0, irq_n}, 0);
        wr(21, 32'h2);
        #1 check("R12 prio above mask", {31'b0, irq_n}, 1);
        wr(1, 5);
        #1 check("R12 prio 5 mask 5 blocked", {31'b0, irq_n}, 0);
        wr(1, 4);
        #1 check("R12 prio 5 mask 4", {31'b0, irq_n}, 1);
        wr(7, 32'h2);
        #1 check("R12 fast request", {30'b0, irq_n, irq_f}, 32'h1);
        wr(7, 0); wr(21, 0); wr(15, 0); wr(1, 32'h1F);
    endtask

    task automatic t_addr;
        wr(32'h41, 0); wr(32'hBF, 0); wr(32'h40, 0);
        rchk("R13 table writes do not alias mask", 1, 32'h1F);
        rchk("R13 word 0x40 constant", 32'h40, 32'd4);
        rchk("R13 table word reads zero", 32'h41, 0);
        rchk("R13 unmapped reads zero", 26, 0);
        rchk("R13 top unmapped reads zero", 32'h3FF, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_pending;
        t_enable_num;
        t_halves;
        t_norm_vec;
        t_fast_vec;
        t_force;
        t_readonly;
        t_mask_ctl;
        t_irq;
        t_addr;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule